// File: doc/BRIEF.md
# Dual-Timebase Capture/Compare Channel Array

This block holds two 16-bit up-counting timebases and an array of sixteen channel registers. Each channel is tied to one of the two timebases. It either records the timebase value when its input pin rises, or it compares its register against the timebase. On a compare it can raise an event pulse, toggle its pin, or set its pin and clear it again when the timebase wraps. Each timebase has a reload register. When the count passes its maximum, the reload value is loaded and a one-cycle wrap strobe is produced.

Software sets up the timers and channels through a flat register port with a synchronous write and a combinational read. Per-timer tick inputs set the counting rate. The first timebase can instead count rising edges of an external event input. Two features let one pin carry more than a single register's events. In paired mode, an even channel and the odd channel above it share the even pin. In one-shot mode, a channel disarms itself after its first event, which gives a single edge or a single pulse.

Top module: `ccu_array`

## Requirements
- R1: Register map: channel values at addresses 0..15, channel configs at 16..31, timebase A count/reload at 32/33, timebase B count/reload at 34/35, control at 36 (bit0 runs A, bit1 runs B, bit2 makes A count external edges). A running timebase adds one on each cycle where its tick is high. From 0xFFFF it loads its reload value and strobes wrap. A software write to the count replaces it.
- R2: When control bit2 is set, timebase A ignores its tick and advances once per rising edge of the synchronized `ext_evt` input.
- R3: Config word: bit0 selects the timebase (0 = A, 1 = B), bits 3:1 give the kind (0 off, 1 capture, 4..7 compare modes 0..3), bit4 selects one-shot, bit5 selects pairing (even channels only), and bit6 reads back as the armed flag. A channel follows only its selected timebase.
- R4: A compare match needs the timebase to have just advanced to a value equal to the channel register. A stalled timebase, or one written by software, produces no match.
- R5: Mode 0 gives an `irq` pulse one cycle after every match and leaves the pin unchanged.
- R6: Mode 1 toggles the pin and pulses `irq` on every match.
- R7: Mode 2 pulses `irq` for at most one match per timebase period. The lock is released when the selected timebase wraps.
- R8: Mode 3 sets the pin on a match and clears it on a wrap of the selected timebase, with at most one event per period. A match in the wrap cycle sets the pin.
- R9: With pairing set on even channel i, pin i toggles on an accepted event of channel i or channel i+1. Pin i+1 holds its value.
- R10: In one-shot mode a channel accepts a single event and then clears its armed flag. It matches no more until its config is written again, which re-arms it.
- R11: A capture channel drives `pin_oe` low, latches its timebase value on a rising edge of its pin (two-flop synchronized), and pulses `irq`. Its `pin_out` does not change.
- R12: After reset all counts, reloads, values and configs are zero, `pin_out` and `irq` are zero, and `pin_oe` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 6 | Read address |
| rd_data | output | 16 | Read data (combinational) |
| tmr_tick | input | 2 | Per-timebase count enable |
| ext_evt | input | 1 | External event input for timebase A |
| pin_in | input | 16 | Channel capture inputs |
| pin_out | output | 16 | Channel compare outputs |
| pin_oe | output | 16 | Channel output enables |
| irq | output | 16 | Per-channel one-cycle event pulses |

## Verification
A wrong count of events shows up within one timebase period. A stuck once-per-period lock or an armed flag that is not cleared changes the number of `irq` pulses in the next period, and the flag also reads back wrongly in the config word. A bad pin state, such as a missed toggle, a mode-3 clear that never happens, or a paired pin that is not shared, is visible on `pin_out` one cycle after the timebase reaches the compare value or wraps. Capture timing errors show as a wrong latched value three cycles after the pin rises.

// File: rtl/ccu_pkg.sv
`timescale 1ns/1ps
// ccu_pkg: shared channel configuration types for the capture/compare array.
// Assumes the kind encoding listed in the block brief (R3).
package ccu_pkg;

    typedef enum logic [2:0] {
        K_OFF  = 3'd0,
        K_CAP  = 3'd1,
        K_CMP0 = 3'd4,
        K_CMP1 = 3'd5,
        K_CMP2 = 3'd6,
        K_CMP3 = 3'd7
    } kind_e;

    typedef struct packed {
        logic  armed;     // bit6, read-only status
        logic  pair;      // bit5
        logic  one_shot;  // bit4
        kind_e kind;      // bits 3:1
        logic  tsel;      // bit0
    } ch_cfg_t;

endpackage

// File: rtl/ccu_edge.sv
`timescale 1ns/1ps
// ccu_edge: two-flop synchronizer with rising-edge detect.
// Assumes din is asynchronous; rise is a one-cycle pulse two edges after din rises.
module ccu_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic s1, s2, s3;

    // Shift the input through the synchronizer and the edge-history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= din;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign rise = s2 & ~s3;
endmodule

// File: rtl/ccu_timer.sv
`timescale 1ns/1ps
// ccu_timer: up-counting timebase with reload.
// Assumes step is already qualified by the selected count source; software
// writes of the count take precedence over counting and raise no update strobe.
module ccu_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          step,
    input  logic          cnt_we,
    input  logic          reld_we,
    input  logic [TW-1:0] wdata,
    output logic [TW-1:0] cnt,
    output logic [TW-1:0] reld,
    output logic          upd,
    output logic          ovf
);
    // Advance, reload on wrap, and flag each new value and each wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            reld <= '0;
            upd  <= 1'b0;
            ovf  <= 1'b0;
        end else begin
            upd <= 1'b0;
            ovf <= 1'b0;
            if (reld_we) reld <= wdata;
            if (cnt_we) begin
                cnt <= wdata;
            end else if (run && step) begin
                upd <= 1'b1;
                if (&cnt) begin
                    cnt <= reld;
                    ovf <= 1'b1;
                end else begin
                    cnt <= cnt + TW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/ccu_channel.sv
`timescale 1ns/1ps
// ccu_channel: one capture/compare register with its mode logic and pin.
// Assumes upd/ovf of each timebase are one-cycle strobes aligned with the new
// count. Pairing inputs are resolved by the parent: ext_tog carries the
// partner's accepted event, pin_hold freezes the pin of an odd partner.
module ccu_channel
    import ccu_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic          val_we,
    input  logic [TW-1:0] wdata,
    input  logic [TW-1:0] t_cnt0,
    input  logic [TW-1:0] t_cnt1,
    input  logic [1:0]    t_upd,
    input  logic [1:0]    t_ovf,
    input  logic          pin_in,
    input  logic          pair_en,
    input  logic          ext_tog,
    input  logic          pin_hold,
    output logic [TW-1:0] val,
    output ch_cfg_t       cfg,
    output logic          pin_out,
    output logic          pin_oe,
    output logic          evt,
    output logic          irq
);
    logic [TW-1:0] cur_cnt;
    logic          cur_upd, cur_ovf;
    logic          is_cmp, is_once, is_cap;
    logic          match, accept, lock, cap_rise;

    ccu_edge u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin_in),
        .rise (cap_rise)
    );

    // Route the selected timebase and decode the mode.
    always_comb begin
        cur_cnt = cfg.tsel ? t_cnt1 : t_cnt0;
        cur_upd = cfg.tsel ? t_upd[1] : t_upd[0];
        cur_ovf = cfg.tsel ? t_ovf[1] : t_ovf[0];
        is_cap  = (cfg.kind == K_CAP);
        is_cmp  = cfg.kind[2];
        is_once = (cfg.kind == K_CMP2) || (cfg.kind == K_CMP3);
        match   = is_cmp && cfg.armed && cur_upd && (cur_cnt == val);
        accept  = match && (!is_once || !lock || cur_ovf);
    end

    assign evt    = accept;
    assign pin_oe = ~is_cap;

    // Configuration register; a write re-arms, a one-shot event disarms.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '{armed: 1'b0, pair: 1'b0, one_shot: 1'b0, kind: K_OFF, tsel: 1'b0};
        end else if (cfg_we) begin
            cfg.tsel     <= wdata[0];
            cfg.kind     <= kind_e'(wdata[3:1]);
            cfg.one_shot <= wdata[4];
            cfg.pair     <= wdata[5];
            cfg.armed    <= 1'b1;
        end else if (accept && cfg.one_shot) begin
            cfg.armed <= 1'b0;
        end
    end

    // Value register: software write wins over a capture in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val <= '0;
        end else if (val_we) begin
            val <= wdata;
        end else if (is_cap && cap_rise) begin
            val <= cur_cnt;
        end
    end

    // Once-per-period lock, released by a wrap of the selected timebase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock <= 1'b0;
        end else if (cfg_we) begin
            lock <= 1'b0;
        end else if (accept && is_once) begin
            lock <= 1'b1;
        end else if (cur_ovf) begin
            lock <= 1'b0;
        end
    end

    // Pin state by mode, with pairing overriding the channel's own mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_out <= 1'b0;
        end else if (pin_hold) begin
            pin_out <= pin_out;
        end else if (pair_en) begin
            if (accept || ext_tog) pin_out <= ~pin_out;
        end else if (cfg.kind == K_CMP1) begin
            if (accept) pin_out <= ~pin_out;
        end else if (cfg.kind == K_CMP3) begin
            if (accept)       pin_out <= 1'b1;
            else if (cur_ovf) pin_out <= 1'b0;
        end
    end

    // One-cycle event pulse for compares and captures.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= accept || (is_cap && cap_rise);
    end
endmodule

// File: rtl/ccu_array.sv
`timescale 1ns/1ps
// ccu_array: two timebases plus an array of capture/compare channels with a
// flat register port. Assumes NCH is an even power of two; address map per R1.
module ccu_array
    import ccu_pkg::*;
#(
    parameter int NCH = 16,
    parameter int TW  = 16,
    parameter int AW  = $clog2(2 * NCH + 5)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [TW-1:0]  wr_data,
    input  logic [AW-1:0]  rd_addr,
    output logic [TW-1:0]  rd_data,
    input  logic [1:0]     tmr_tick,
    input  logic           ext_evt,
    input  logic [NCH-1:0] pin_in,
    output logic [NCH-1:0] pin_out,
    output logic [NCH-1:0] pin_oe,
    output logic [NCH-1:0] irq
);
    localparam int IW = $clog2(NCH);
    localparam logic [AW-1:0] A_CFG = AW'(NCH);
    localparam logic [AW-1:0] A_T0C = AW'(2 * NCH);
    localparam logic [AW-1:0] A_T0R = AW'(2 * NCH + 1);
    localparam logic [AW-1:0] A_T1C = AW'(2 * NCH + 2);
    localparam logic [AW-1:0] A_T1R = AW'(2 * NCH + 3);
    localparam logic [AW-1:0] A_CTL = AW'(2 * NCH + 4);

    logic [1:0]       run;
    logic             t0_ext, ext_rise;
    logic [1:0]       step, t_upd, t_ovf;
    logic [TW-1:0]    t_cnt  [2];
    logic [TW-1:0]    t_reld [2];
    logic [TW-1:0]    ch_val [NCH];
    ch_cfg_t          ch_cfg [NCH];
    logic [NCH-1:0]   ch_evt;
    logic [NCH-1:0]   pair_eff;
    logic [3*NCH-1:0] kind_flat;
    logic [IW-1:0]    rd_idx;

    // Control register: run bits and external source select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run    <= 2'b00;
            t0_ext <= 1'b0;
        end else if (wr_en && wr_addr == A_CTL) begin
            run    <= wr_data[1:0];
            t0_ext <= wr_data[2];
        end
    end

    ccu_edge u_ext (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (ext_evt),
        .rise (ext_rise)
    );

    assign step[0] = t0_ext ? ext_rise : tmr_tick[0];
    assign step[1] = tmr_tick[1];

    for (genvar g = 0; g < 2; g++) begin : g_tmr
        localparam logic [AW-1:0] A_C = (g == 0) ? A_T0C : A_T1C;
        localparam logic [AW-1:0] A_R = (g == 0) ? A_T0R : A_T1R;
        ccu_timer #(.TW(TW)) u_tmr (
            .clk    (clk),
            .rst_n  (rst_n),
            .run    (run[g]),
            .step   (step[g]),
            .cnt_we (wr_en && wr_addr == A_C),
            .reld_we(wr_en && wr_addr == A_R),
            .wdata  (wr_data),
            .cnt    (t_cnt[g]),
            .reld   (t_reld[g]),
            .upd    (t_upd[g]),
            .ovf    (t_ovf[g])
        );
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic ext_tog_i, hold_i;
        if ((i % 2) == 0) begin : g_even
            assign pair_eff[i] = ch_cfg[i].pair;
            assign ext_tog_i   = ch_cfg[i].pair & ch_evt[i+1];
            assign hold_i      = 1'b0;
        end else begin : g_odd
            assign pair_eff[i] = 1'b0;
            assign ext_tog_i   = 1'b0;
            assign hold_i      = ch_cfg[i-1].pair;
        end
        assign kind_flat[3*i +: 3] = ch_cfg[i].kind;

        ccu_channel #(.TW(TW)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .cfg_we  (wr_en && wr_addr == AW'(NCH + i)),
            .val_we  (wr_en && wr_addr == AW'(i)),
            .wdata   (wr_data),
            .t_cnt0  (t_cnt[0]),
            .t_cnt1  (t_cnt[1]),
            .t_upd   (t_upd),
            .t_ovf   (t_ovf),
            .pin_in  (pin_in[i]),
            .pair_en (pair_eff[i]),
            .ext_tog (ext_tog_i),
            .pin_hold(hold_i),
            .val     (ch_val[i]),
            .cfg     (ch_cfg[i]),
            .pin_out (pin_out[i]),
            .pin_oe  (pin_oe[i]),
            .evt     (ch_evt[i]),
            .irq     (irq[i])
        );
    end

    assign rd_idx = rd_addr[IW-1:0];

    // Combinational read multiplexer over the address map.
    always_comb begin
        rd_data = '0;
        if (rd_addr < A_CFG) begin
            rd_data = ch_val[rd_idx];
        end else if (rd_addr < A_T0C) begin
            rd_data = TW'(ch_cfg[rd_idx]);
        end else begin
            case (rd_addr)
                A_T0C:   rd_data = t_cnt[0];
                A_T0R:   rd_data = t_reld[0];
                A_T1C:   rd_data = t_cnt[1];
                A_T1R:   rd_data = t_reld[1];
                A_CTL:   rd_data = TW'({t0_ext, run});
                default: rd_data = '0;
            endcase
        end
    end
endmodule

// File: rtl/ccu_array_chk.sv
`timescale 1ns/1ps
// ccu_array_chk: temporal properties of the timebases and pin behaviour,
// bound into ccu_array. Assumes the kind encoding of ccu_pkg.
module ccu_array_chk #(
    parameter int NCH = 16,
    parameter int TW  = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic [TW-1:0]  t_cnt0,
    input logic [TW-1:0]  t_cnt1,
    input logic [1:0]     t_upd,
    input logic [1:0]     t_ovf,
    input logic [1:0]     run,
    input logic [NCH-1:0] pin_out,
    input logic [NCH-1:0] pair_eff,
    input logic [3*NCH-1:0] kind_flat
);
    AST_WRAP_FROM_MAX_A: assert property (@(posedge clk) disable iff (!rst_n)
        t_ovf[0] |-> ($past(t_cnt0) == {TW{1'b1}}));                                 // R1
    AST_WRAP_FROM_MAX_B: assert property (@(posedge clk) disable iff (!rst_n)
        t_ovf[1] |-> ($past(t_cnt1) == {TW{1'b1}}));                                 // R1
    AST_STEP_BY_ONE_A: assert property (@(posedge clk) disable iff (!rst_n)
        (t_upd[0] && !t_ovf[0]) |-> (t_cnt0 == $past(t_cnt0) + TW'(1)));             // R1
    AST_STEP_BY_ONE_B: assert property (@(posedge clk) disable iff (!rst_n)
        (t_upd[1] && !t_ovf[1]) |-> (t_cnt1 == $past(t_cnt1) + TW'(1)));             // R1
    AST_STALL_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        !run[0] |=> !t_upd[0]);                                                       // R4

    for (genvar i = 0; i < NCH; i++) begin : g_pin
        AST_INTONLY_PIN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
            (($past(kind_flat[3*i +: 3]) == 3'd4 || $past(kind_flat[3*i +: 3]) == 3'd6)
             && !$past(pair_eff[i])) |-> $stable(pin_out[i]));                      // R5
        AST_CAP_PIN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(kind_flat[3*i +: 3]) == 3'd1 && !$past(pair_eff[i]))
            |-> $stable(pin_out[i]));                                               // R11
    end
endmodule

bind ccu_array ccu_array_chk #(.NCH(NCH), .TW(TW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .t_cnt0   (t_cnt[0]),
    .t_cnt1   (t_cnt[1]),
    .t_upd    (t_upd),
    .t_ovf    (t_ovf),
    .run      (run),
    .pin_out  (pin_out),
    .pair_eff (pair_eff),
    .kind_flat(kind_flat)
);

// File: tb/ccu_array_tb.sv
`timescale 1ns/1ps
module ccu_array_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [5:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [1:0]  tmr_tick = '0;
    logic        ext_evt = 1'b0;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out, pin_oe, irq;

    int n_run = 0;
    int n_fail = 0;
    int irq_cnt [16];
    bit done = 1'b0;

    always #10 clk = ~clk;

    ccu_array u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .tmr_tick(tmr_tick), .ext_evt(ext_evt), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    initial for (int i = 0; i < 16; i++) irq_cnt[i] = 0;

    always @(negedge clk)
        for (int i = 0; i < 16; i++) if (irq[i]) irq_cnt[i] = irq_cnt[i] + 1;

    // Row: config word, compare value, expected irq count and final pin over
    // 40 ticks with reload 0xFFF0 starting at count 0xFFF0.
    typedef struct packed {
        logic [15:0] cfg;
        logic [15:0] val;
        logic [7:0]  n_irq;
        logic        pin;
    } row_t;

    localparam row_t ROWS [11] = '{
        '{16'h0008, 16'hFFF3, 8'd3, 1'b0},  // R5
        '{16'h0008, 16'hFFFA, 8'd2, 1'b0},  // R5
        '{16'h000A, 16'hFFF3, 8'd3, 1'b1},  // R6
        '{16'h000A, 16'hFFFA, 8'd2, 1'b0},  // R6
        '{16'h000C, 16'hFFF3, 8'd3, 1'b0},  // R7
        '{16'h000E, 16'hFFF3, 8'd3, 1'b1},  // R8
        '{16'h000E, 16'hFFFA, 8'd2, 1'b0},  // R8
        '{16'h001A, 16'hFFF3, 8'd1, 1'b1},  // R10
        '{16'h001E, 16'hFFF3, 8'd1, 1'b0},  // R10
        '{16'h0008, 16'hFFF0, 8'd2, 1'b0},  // R5 match on reload value
        '{16'h000E, 16'hFFF0, 8'd2, 1'b1}   // R8 set wins in wrap cycle
    };

    function automatic string tag_of(logic [15:0] c);
        if (c[4]) return "R10";
        case (c[3:1])
            3'd4:    return "R5";
            3'd5:    return "R6";
            3'd6:    return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wr(logic [5:0] a, logic [15:0] d);
        settle();
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        settle();
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [5:0] a, output logic [15:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic ticks(int n, logic [1:0] m);
        settle();
        tmr_tick = m;
        repeat (n) settle();
        tmr_tick = '0;
    endtask

    task automatic do_reset();
        settle();
        rst_n = 1'b0;
        pin_in = '0; ext_evt = 1'b0; tmr_tick = '0;
        repeat (3) settle();
        rst_n = 1'b1;
        settle();
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] d;
        int b0, b1;

        // Table-driven compare-mode runs.
        for (int r = 0; r < 11; r++) begin
            do_reset();
            wr(6'd33, 16'hFFF0);
            wr(6'd32, 16'hFFF0);
            wr(6'd0, ROWS[r].val);
            wr(6'd16, ROWS[r].cfg);
            wr(6'd36, 16'h0001);
            b0 = irq_cnt[0];
            ticks(40, 2'b01);
            repeat (4) settle();
            chk({tag_of(ROWS[r].cfg), " irq count"}, irq_cnt[0] - b0, ROWS[r].n_irq);
            chk({tag_of(ROWS[r].cfg), " pin"}, pin_out[0], ROWS[r].pin);
        end

        // R12 reset state.
        do_reset();
        chk("R12 pin_out", pin_out, 16'h0000);
        chk("R12 irq", irq, 16'h0000);
        chk("R12 pin_oe", pin_oe, 16'hFFFF);
        rd(6'd32, d); chk("R12 count", d, 16'h0000);
        rd(6'd16, d); chk("R12 cfg", d, 16'h0000);

        // R4 stalled timebase equal to compare value; R1 single step.
        wr(6'd0, 16'h0003);
        wr(6'd16, 16'h0008);
        wr(6'd32, 16'h0003);
        wr(6'd36, 16'h0001);
        b0 = irq_cnt[0];
        repeat (10) settle();
        chk("R4 no match when stalled", irq_cnt[0] - b0, 0);
        ticks(1, 2'b01);
        repeat (2) settle();
        rd(6'd32, d); chk("R1 count step", d, 16'h0004);
        chk("R4 no match on other value", irq_cnt[0] - b0, 0);

        // R5/R7 rewrite of compare value within a period.
        do_reset();
        wr(6'd33, 16'hFFF0);
        wr(6'd32, 16'hFFF2);
        wr(6'd0, 16'hFFF3); wr(6'd16, 16'h0008);
        wr(6'd1, 16'hFFF3); wr(6'd17, 16'h000C);
        wr(6'd36, 16'h0001);
        b0 = irq_cnt[0]; b1 = irq_cnt[1];
        ticks(1, 2'b01); repeat (2) settle();
        wr(6'd0, 16'hFFF5); wr(6'd1, 16'hFFF5);
        ticks(2, 2'b01); repeat (2) settle();
        chk("R5 second match same period", irq_cnt[0] - b0, 2);
        chk("R7 second match locked", irq_cnt[1] - b1, 1);
        ticks(11, 2'b01);
        ticks(5, 2'b01); repeat (2) settle();
        chk("R7 lock released by wrap", irq_cnt[1] - b1, 2);
        rd(6'd32, d); chk("R1 reload after wrap", d, 16'hFFF5);

        // R3 binding to timebase B.
        do_reset();
        wr(6'd7, 16'h0005);
        wr(6'd23, 16'h000B);
        wr(6'd36, 16'h0003);
        ticks(5, 2'b10); repeat (2) settle();
        chk("R3 pin on timebase B", pin_out[7], 1'b1);
        rd(6'd32, d); chk("R3 timebase A idle", d, 16'h0000);
        rd(6'd34, d); chk("R3 timebase B count", d, 16'h0005);

        // R9 paired channels 2 and 3.
        do_reset();
        wr(6'd33, 16'hFFF0); wr(6'd32, 16'hFFF0);
        wr(6'd2, 16'hFFF3); wr(6'd18, 16'h0028);
        wr(6'd3, 16'hFFF6); wr(6'd19, 16'h000A);
        wr(6'd36, 16'h0001);
        ticks(5, 2'b01); repeat (2) settle();
        chk("R9 own event toggles", pin_out[2], 1'b1);
        ticks(2, 2'b01); repeat (2) settle();
        chk("R9 partner event toggles", pin_out[2], 1'b0);
        chk("R9 partner pin held", pin_out[3], 1'b0);

        // R10 disarm readback and re-arm.
        do_reset();
        wr(6'd33, 16'hFFF0); wr(6'd32, 16'hFFF0);
        wr(6'd0, 16'hFFF3); wr(6'd16, 16'h001A);
        rd(6'd16, d); chk("R10 armed after write", d[6], 1'b1);
        wr(6'd36, 16'h0001);
        ticks(20, 2'b01); repeat (2) settle();
        chk("R10 single edge", pin_out[0], 1'b1);
        rd(6'd16, d); chk("R10 disarmed", d[6], 1'b0);
        wr(6'd16, 16'h001A);
        ticks(15, 2'b01); repeat (2) settle();
        chk("R10 re-armed edge", pin_out[0], 1'b0);

        // R11 capture on channel 5.
        do_reset();
        wr(6'd32, 16'h1234);
        wr(6'd21, 16'h0002);
        chk("R11 pin_oe low", pin_oe[5], 1'b0);
        b0 = irq_cnt[5];
        settle(); pin_in[5] = 1'b1;
        repeat (6) settle();
        rd(6'd5, d); chk("R11 captured value", d, 16'h1234);
        chk("R11 capture irq", irq_cnt[5] - b0, 1);
        chk("R11 pin unchanged", pin_out[5], 1'b0);

        // R2 external-edge counting on timebase A.
        do_reset();
        wr(6'd36, 16'h0005);
        tmr_tick = 2'b01;
        for (int k = 0; k < 3; k++) begin
            ext_evt = 1'b1; repeat (3) settle();
            ext_evt = 1'b0; repeat (3) settle();
        end
        tmr_tick = 2'b00;
        repeat (4) settle();
        rd(6'd32, d); chk("R2 external edges counted", d, 16'h0003);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule